// File: doc/BRIEF.md
# Pipelined Prime-Field Fold Reducer

This block reduces a wide product modulo the prime 2^130-5. The product comes from multiplying an accumulated sum below 2^131 by a 128-bit key whose bits have been cleared by the usual clamp mask, so it is at most 259 bits wide. The block does not divide. It uses the congruence 2^130 ≡ 5. Each fold step splits its operand at bit 130 and produces five times the upper part plus the lower 130 bits. Five times a value is formed as the value plus the value shifted left by two. No general multiplier is used.

There is one register stage per fold, and two folds are enough for every legal operand. A valid flag travels with the data through every stage. When the canonical option is set, one extra stage subtracts the prime once if the folded value is at least the prime, so the residue is fully reduced. The block sits between a wide multiplier and the feedback path of an accumulator. It accepts one operand per clock and has no back-pressure.

Top module: `fold_reducer`

## Requirements
- R1: For every legal operand (a value below 2^131 times a key ANDed with 0x0ffffffc0ffffffc0ffffffc0fffffff), with the canonical stage enabled, `res_o` equals the operand modulo 2^130-5.
- R2: A result appears on `res_o` with `out_valid_o` high exactly NUM_FOLDS+1 clocks after its operand was presented with `in_valid_i` high. This is 3 clocks by default. One operand is accepted every clock.
- R3: For legal operands, the second fold never produces a bit at or above position 130, so truncating it to 130 bits loses nothing.
- R4: For the worst-case operand (2^131-1 times 0x0ffffffc0ffffffc0ffffffc0fffffff), the first fold yields 0x48fffffdc8fffffdc8fffffdc8ffffff2 and the final result is 0x8fffffdc8fffffdc8fffffdc8ffffff7.
- R5: With the canonical stage enabled, every valid result is below 2^130-5, and an operand that is a multiple of the prime reduces to 0.
- R6: A cycle with `in_valid_i` low yields a cycle with `out_valid_o` low at the matching output slot, whatever `prod_i` carried. The valid pattern at the output repeats the input pattern after the fixed latency.
- R7: While `rst_ni` is low, every valid stage is cleared at once. `out_valid_o` stays low until a new operand has crossed the pipeline.
- R8: A zero operand gives a zero first fold and a zero result.
- R9: With the canonical stage disabled (CANON=0), results appear NUM_FOLDS clocks after their operand (2 by default). Each result is below 2^130 and congruent to the operand modulo 2^130-5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low, clears the valid stages |
| in_valid_i | input | 1 | Operand on `prod_i` is valid this cycle |
| prod_i | input | IN_W (259) | Wide product to reduce |
| out_valid_o | output | 1 | `res_o` holds a result this cycle |
| res_o | output | RES_W (130) | Residue modulo 2^130-5 |

## Verification
Random products of a 131-bit value and a clamped key test the general congruence. Each of these results is also compared with the prime, which catches a missing or mis-set final subtraction. The all-ones-times-maximum-key operand drives both folds to their largest carries. It is the only pattern that would expose a fold register one bit too narrow or a truncation made too early. Zero and exact multiples of the prime sit on the wrap-around boundary, where an off-by-one in the compare would show up as P instead of 0. Bubbles with random data on `prod_i`, a reset asserted in mid-stream, and a second instance built without the canonical stage show whether the valid flag is aligned with the data in both latency variants.

// File: rtl/fold_reducer_pkg.sv
package fold_reducer_pkg;

  // 2^RES_W is congruent to FOLD_C modulo the prime 2^RES_W - FOLD_C
  localparam int FOLD_C     = 5;
  localparam int MUL_SHIFT  = 2;   // FOLD_C = 1 + (1 << MUL_SHIFT)
  localparam int FOLD_GROW  = MUL_SHIFT + 1;

  // Width of the operand held after k folds.
  function automatic int fold_w(input int in_w, input int res_w, input int k);
    int w;
    w = in_w;
    for (int i = 0; i < k; i++) begin
      w = (((w - res_w + FOLD_GROW) > res_w) ? (w - res_w + FOLD_GROW) : res_w) + 1;
    end
    return w;
  endfunction

endpackage

// File: rtl/fold_unit.sv
module fold_unit
  import fold_reducer_pkg::*;
#(
  parameter int IN_W  = 259,
  parameter int OUT_W = 133,
  parameter int RES_W = 130
) (
  input  logic [IN_W-1:0]  x_i,
  output logic [OUT_W-1:0] y_o
);

  localparam int HI_W = IN_W - RES_W;

  logic [HI_W-1:0]  hi;
  logic [RES_W-1:0] lo;

  assign {hi, lo} = x_i;

  // hi * 5 as hi + (hi << 2), no multiplier
  assign y_o = OUT_W'(hi) + (OUT_W'(hi) << MUL_SHIFT) + OUT_W'(lo);

endmodule

// File: rtl/stage_reg.sv
module stage_reg #(
  parameter int W = 130
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         vld_i,
  input  logic [W-1:0] d_i,
  output logic         vld_o,
  output logic [W-1:0] q_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_o <= 1'b0;
    else         vld_o <= vld_i;
  end

  // data is not reset; captured only with a valid beat
  always_ff @(posedge clk_i) begin
    if (vld_i) q_o <= d_i;
  end

endmodule

// File: rtl/canon_unit.sv
module canon_unit
  import fold_reducer_pkg::*;
#(
  parameter int W = 130
) (
  input  logic [W-1:0] x_i,
  output logic [W-1:0] y_o
);

  localparam logic [W-1:0] MODULUS = {W{1'b1}} - W'(FOLD_C - 1);

  // input < 2^W < 2*MODULUS, so one subtraction suffices
  assign y_o = (x_i >= MODULUS) ? (x_i - MODULUS) : x_i;

endmodule

// File: rtl/fold_reducer.sv
module fold_reducer
  import fold_reducer_pkg::*;
#(
  parameter int IN_W      = 259,
  parameter int RES_W     = 130,
  parameter int NUM_FOLDS = 2,
  parameter bit CANON     = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  input  logic [IN_W-1:0]  prod_i,
  output logic             out_valid_o,
  output logic [RES_W-1:0] res_o
);

  localparam int FIRST_W = fold_w(IN_W, RES_W, 1);
  localparam int LAST_W  = fold_w(IN_W, RES_W, NUM_FOLDS);

  logic               first_vld;
  logic [FIRST_W-1:0] first_q;
  logic               last_vld;
  logic [LAST_W-1:0]  last_q;

  for (genvar k = 0; k < NUM_FOLDS; k++) begin : g_fold
    localparam int SW_IN  = fold_w(IN_W, RES_W, k);
    localparam int SW_OUT = fold_w(IN_W, RES_W, k + 1);

    logic [SW_IN-1:0]  src;
    logic              src_vld;
    logic [SW_OUT-1:0] sum;
    logic [SW_OUT-1:0] q;
    logic              vld;

    if (k == 0) begin : g_head
      assign src     = prod_i;
      assign src_vld = in_valid_i;
    end else begin : g_link
      assign src     = g_fold[k-1].q;
      assign src_vld = g_fold[k-1].vld;
    end

    fold_unit #(.IN_W(SW_IN), .OUT_W(SW_OUT), .RES_W(RES_W)) u_fold (
      .x_i(src),
      .y_o(sum)
    );

    stage_reg #(.W(SW_OUT)) u_reg (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .vld_i (src_vld),
      .d_i   (sum),
      .vld_o (vld),
      .q_o   (q)
    );
  end

  assign first_vld = g_fold[0].vld;
  assign first_q   = g_fold[0].q;
  assign last_vld  = g_fold[NUM_FOLDS-1].vld;
  assign last_q    = g_fold[NUM_FOLDS-1].q;

  if (CANON) begin : g_canon
    logic [RES_W-1:0] canon_d;

    canon_unit #(.W(RES_W)) u_canon (
      .x_i(last_q[RES_W-1:0]),
      .y_o(canon_d)
    );

    stage_reg #(.W(RES_W)) u_out (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .vld_i (last_vld),
      .d_i   (canon_d),
      .vld_o (out_valid_o),
      .q_o   (res_o)
    );
  end else begin : g_raw
    assign out_valid_o = last_vld;
    assign res_o       = last_q[RES_W-1:0];
  end

endmodule

// File: rtl/fold_reducer_chk.sv
module fold_reducer_chk
  import fold_reducer_pkg::*;
#(
  parameter int IN_W    = 259,
  parameter int RES_W   = 130,
  parameter int FIRST_W = 133,
  parameter int LAST_W  = 131,
  parameter bit CANON   = 1'b1
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               in_valid_i,
  input logic [IN_W-1:0]    prod_i,
  input logic               out_valid_o,
  input logic [RES_W-1:0]   res_o,
  input logic               first_vld,
  input logic [FIRST_W-1:0] first_q,
  input logic               last_vld,
  input logic [LAST_W-1:0]  last_q
);

  localparam logic [RES_W-1:0] MODULUS = {RES_W{1'b1}} - RES_W'(FOLD_C - 1);
  localparam bit KAT_ON = (IN_W == 259) && (RES_W == 130);
  localparam logic [IN_W-1:0] WORST_IN =
    IN_W'(259'h7fffffe07fffffe07fffffe07ffffff7f0000003f0000003f0000003f0000001);
  localparam logic [FIRST_W-1:0] WORST_F1 =
    FIRST_W'(131'h48fffffdc8fffffdc8fffffdc8ffffff2);

  p_first_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    first_vld == $past(in_valid_i));

  if (CANON) begin : g_canon_chk
    p_out_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      out_valid_o == $past(last_vld));

    p_canon_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      out_valid_o |-> (res_o < MODULUS));
  end

  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_vld |-> (last_q[LAST_W-1:RES_W] == '0));

  p_worst_fold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (KAT_ON && first_vld && $past(in_valid_i) && ($past(prod_i) == WORST_IN))
      |-> (first_q == WORST_F1));

  p_zero_fold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (first_vld && $past(in_valid_i) && ($past(prod_i) == '0)) |-> (first_q == '0));

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_clear_r7: assert (!out_valid_o && !first_vld && !last_vld);
    end
  end

endmodule

bind fold_reducer fold_reducer_chk #(
  .IN_W   (IN_W),
  .RES_W  (RES_W),
  .FIRST_W(FIRST_W),
  .LAST_W (LAST_W),
  .CANON  (CANON)
) u_fold_reducer_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .in_valid_i (in_valid_i),
  .prod_i     (prod_i),
  .out_valid_o(out_valid_o),
  .res_o      (res_o),
  .first_vld  (first_vld),
  .first_q    (first_q),
  .last_vld   (last_vld),
  .last_q     (last_q)
);

// File: tb/test_fold_reducer.sv
module test_fold_reducer;

  localparam int IN_W  = 259;
  localparam int RES_W = 130;
  localparam int LAT_C = 3;
  localparam int LAT_R = 2;

  localparam logic [IN_W-1:0] PRIME   = (IN_W'(1) << RES_W) - IN_W'(5);
  localparam logic [127:0]    CLAMP   = 128'h0ffffffc0ffffffc0ffffffc0fffffff;
  localparam logic [RES_W-1:0] WORST_RES = 130'h8fffffdc8fffffdc8fffffdc8ffffff7;

  typedef struct {
    logic            v;
    logic [IN_W-1:0] d;
    string           tag;
  } ent_t;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             in_valid_i = 1'b0;
  logic [IN_W-1:0]  prod_i = '0;
  logic             vld_c, vld_r;
  logic [RES_W-1:0] res_c, res_r;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  ent_t qc[$];
  ent_t qr[$];

  always #5ns clk_i = ~clk_i;

  fold_reducer i_fold_reducer (
    .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid_i), .prod_i(prod_i),
    .out_valid_o(vld_c), .res_o(res_c)
  );

  fold_reducer #(.CANON(1'b0)) i_fold_reducer_raw (
    .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid_i), .prod_i(prod_i),
    .out_valid_o(vld_r), .res_o(res_r)
  );

  function automatic logic [IN_W-1:0] rnd_wide();
    logic [IN_W-1:0] r;
    r = '0;
    for (int i = 0; i < 9; i++) r = (r << 32) | IN_W'($urandom);
    return r;
  endfunction

  function automatic logic [IN_W-1:0] legal_prod(input logic [130:0] a, input logic [127:0] key);
    return IN_W'(a) * IN_W'(key & CLAMP);
  endfunction

  task automatic fail(input string tag, input logic [IN_W-1:0] act, input logic [IN_W-1:0] exp);
    n_fail++;
    $display("FAIL %s: actual %h expected %h", tag, act, exp);
  endtask

  task automatic fill_queues();
    ent_t e;
    e.v = 1'b0; e.d = '0; e.tag = "R7";
    qc.delete(); qr.delete();
    for (int i = 0; i < LAT_C; i++) qc.push_back(e);
    for (int i = 0; i < LAT_R; i++) qr.push_back(e);
  endtask

  // at a falling edge: compare outputs, then drive the next beat
  task automatic step(input logic v, input logic [IN_W-1:0] d, input string tag);
    ent_t ec, er, en;
    logic [IN_W-1:0] m;
    @(negedge clk_i);
    ec = qc.pop_front();
    er = qr.pop_front();
    n_chk++;
    if (vld_c !== ec.v) fail({ec.tag, " R2 R6 valid"}, IN_W'(vld_c), IN_W'(ec.v));
    n_chk++;
    if (vld_r !== er.v) fail({er.tag, " R9 valid"}, IN_W'(vld_r), IN_W'(er.v));
    if (ec.v) begin
      m = ec.d % PRIME;
      n_chk++;
      if (res_c !== m[RES_W-1:0]) fail({ec.tag, " R1 residue"}, IN_W'(res_c), m);
      n_chk++;
      if (IN_W'(res_c) >= PRIME) fail({ec.tag, " R5 range"}, IN_W'(res_c), PRIME);
      if (ec.tag == "R4") begin
        n_chk++;
        if (res_c !== WORST_RES) fail("R4 worst result", IN_W'(res_c), IN_W'(WORST_RES));
      end
      if (ec.tag == "R8" || ec.tag == "R5") begin
        n_chk++;
        if (res_c !== '0) fail({ec.tag, " zero result"}, IN_W'(res_c), '0);
      end
    end
    if (er.v) begin
      n_chk++;
      if ((IN_W'(res_r) % PRIME) !== (er.d % PRIME))
        fail({er.tag, " R9 congruence"}, IN_W'(res_r) % PRIME, er.d % PRIME);
    end
    in_valid_i = v;
    prod_i = d;
    en.v = v; en.d = d; en.tag = tag;
    qc.push_back(en);
    qr.push_back(en);
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    in_valid_i = 1'b0;
    #1ns;
    n_chk++;
    if (vld_c !== 1'b0) fail("R7 async clear", IN_W'(vld_c), '0);
    n_chk++;
    if (vld_r !== 1'b0) fail("R7 async clear raw", IN_W'(vld_r), '0);
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    fill_queues();
  endtask

  initial begin
    #(10ns * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    fill_queues();
    repeat (3) @(negedge clk_i);
    n_chk++;
    if (vld_c !== 1'b0) fail("R7 reset state", IN_W'(vld_c), '0);
    rst_ni = 1'b1;

    // R4 worst case, R8 zero
    step(1'b1, legal_prod({131{1'b1}}, CLAMP), "R4");
    step(1'b1, '0, "R8");
    // R5 multiples of the prime
    step(1'b1, legal_prod(131'(PRIME), 128'd1), "R5");
    step(1'b1, legal_prod(131'(PRIME), CLAMP), "R5");
    for (int i = 0; i < 20; i++)
      step(1'b1, legal_prod(131'(PRIME), rnd_wide()[127:0]), "R5");
    // R1 random back-to-back
    for (int i = 0; i < 400; i++)
      step(1'b1, legal_prod(rnd_wide()[130:0], rnd_wide()[127:0]), "R1");
    // R6 bubbles carrying junk data
    for (int i = 0; i < 200; i++) begin
      if ($urandom_range(0, 2) == 0) step(1'b0, rnd_wide(), "R6");
      else step(1'b1, legal_prod(rnd_wide()[130:0], rnd_wide()[127:0]), "R6");
    end
    // R3 large operands near the top of the range
    for (int i = 0; i < 50; i++)
      step(1'b1, legal_prod({2'b11, rnd_wide()[128:0]}, rnd_wide()[127:0] | 128'h0f000000_0f000000_0f000000_0f000000), "R3");
    // R7 reset with data in flight
    step(1'b1, legal_prod(rnd_wide()[130:0], CLAMP), "R7");
    step(1'b1, legal_prod(rnd_wide()[130:0], CLAMP), "R7");
    do_reset();
    for (int i = 0; i < 4; i++) step(1'b0, rnd_wide(), "R7");
    step(1'b1, legal_prod({131{1'b1}}, CLAMP), "R4");
    for (int i = 0; i < 30; i++)
      step(1'b1, legal_prod(rnd_wide()[130:0], rnd_wide()[127:0]), "R1");
    for (int i = 0; i < LAT_C + 2; i++) step(1'b0, '0, "R6");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule